// File: doc/BRIEF.md
# Direct-Mapped Cache with Victim Buffer

This block is a direct-mapped data cache with a small fully associative victim buffer placed between the main array and the next memory level. When a line is displaced from the main array, it is kept in the victim buffer instead of being dropped. When a request misses in the main array, the block then searches the victim buffer. If the buffer holds the line, the buffer entry and the main-array line trade places. Two addresses that share a set can therefore be used alternately without going to memory each time.

The CPU side handles one word request at a time. `cpu_ready` is high while the block is idle, and `cpu_resp_valid` marks the single cycle in which `cpu_rdata` is valid. Writes use write-back and write-allocate. The memory side moves whole lines. A request is held until `mem_req_ready` accepts it. A read completes when `mem_resp_valid` delivers the line.

Top module: `victim_assist_cache`

## Requirements
- R1: While rst_n is low and after it rises, cpu_ready=1, cpu_resp_valid=0 and mem_req_valid=0. Reset invalidates every line in both structures and writes nothing back, so the next access issues a memory read.
- R2: The word address is split as follows: bits [1:0] select the word in the line, bits [5:2] select the set, and bits [15:6] are the tag. On a main-array hit, cpu_resp_valid and cpu_rdata appear in the first cycle after the accepting edge, and no memory request is made.
- R3: A write hit replaces only the addressed word, which occupies line bits [32w+31:32w]. The other words of the line keep their values.
- R4: A miss in both structures issues exactly one memory read, with mem_req_addr = cpu_addr[15:2]. The response returns word cpu_addr[1:0] of the fetched line.
- R5: The line displaced from the main array enters the victim buffer. A later access to that line is served with no memory traffic, two cycles later than a main-array hit, and the line moves back into the main array.
- R6: Two lines of the same set accessed alternately cause no memory traffic once both are loaded. Written data survives the swaps.
- R7: The victim buffer holds 4 lines. When it is full, an incoming displaced line replaces the least recently used entry; an insertion or a swap counts as a use. A line replaced this way needs a memory read when it is next accessed.
- R8: A dirty entry pushed out of the victim buffer is written to memory as a full line at its own line address, before the read for the new line. A clean entry leaves with no write.
- R9: A write miss fetches the line, merges the written word and marks the line dirty. A later read returns the written word.
- R10: A memory request stays asserted, with stable address and direction, until mem_req_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Request strobe, taken when cpu_ready is high |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 16 | Word address |
| cpu_wdata | input | 32 | Write data |
| cpu_ready | output | 1 | Idle, able to take a request |
| cpu_resp_valid | output | 1 | Request completed this cycle |
| cpu_rdata | output | 32 | Read data, valid with cpu_resp_valid |
| mem_req_valid | output | 1 | Memory request pending |
| mem_req_we | output | 1 | 1 = line writeback, 0 = line read |
| mem_req_addr | output | 14 | Line address |
| mem_req_wdata | output | 128 | Line being written back |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_resp_valid | input | 1 | Read line returned |
| mem_resp_data | input | 128 | Returned line |

## Verification
The bench uses six lines that all map to one set. First it repeats accesses to a single line, which separates main-array hits from compulsory fetches. Next it alternates between two lines, which shows whether the swap really removes the memory traffic that conflicts would otherwise cause. It then walks through more conflicting lines than the buffer can hold, and the order of the memory reads shows whether the least recently used entry was the one replaced. A dirty line is pushed out of the buffer and then read again, which shows whether the writeback carried the right data to the right address. The counts of memory reads and writes for each access, and the response latency, tell apart the main-array hit, the buffer hit and the full miss.

// File: rtl/victim_assist_cache.sv
module victim_assist_cache #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int LINES  = 16,
  parameter int WORDS  = 4,
  parameter int VB_N   = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cpu_req,
  input  logic                      cpu_we,
  input  logic [ADDR_W-1:0]         cpu_addr,
  input  logic [DATA_W-1:0]         cpu_wdata,
  output logic                      cpu_ready,
  output logic                      cpu_resp_valid,
  output logic [DATA_W-1:0]         cpu_rdata,
  output logic                      mem_req_valid,
  output logic                      mem_req_we,
  output logic [ADDR_W-$clog2(WORDS)-1:0] mem_req_addr,
  output logic [WORDS*DATA_W-1:0]   mem_req_wdata,
  input  logic                      mem_req_ready,
  input  logic                      mem_resp_valid,
  input  logic [WORDS*DATA_W-1:0]   mem_resp_data
);
  localparam int OFF_W  = $clog2(WORDS);
  localparam int IDX_W  = $clog2(LINES);
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
  localparam int LA_W   = ADDR_W - OFF_W;
  localparam int LINE_W = WORDS * DATA_W;
  localparam int VB_W   = $clog2(VB_N);

  typedef enum logic [2:0] {S_IDLE, S_LOOK, S_PROBE, S_WB, S_MOVE, S_FETCH, S_WAIT} state_t;
  state_t state;

  logic [LINE_W-1:0] m_data [LINES];
  logic [TAG_W-1:0]  m_tag  [LINES];
  logic [LINES-1:0]  m_val, m_dirty;

  logic [LINE_W-1:0] vb_data [VB_N];
  logic [LA_W-1:0]   vb_la   [VB_N];
  logic [VB_W-1:0]   vb_age  [VB_N];
  logic [VB_N-1:0]   vb_val, vb_dirty;

  logic              req_we;
  logic [ADDR_W-1:0] req_addr;
  logic [DATA_W-1:0] req_wdata;
  logic [VB_W-1:0]   slot;

  wire [IDX_W-1:0] idx = req_addr[OFF_W +: IDX_W];
  wire [TAG_W-1:0] tag = req_addr[ADDR_W-1 -: TAG_W];
  wire [OFF_W-1:0] off = req_addr[OFF_W-1:0];
  wire [LA_W-1:0]  la  = req_addr[ADDR_W-1:OFF_W];
  wire             m_hit = m_val[idx] && (m_tag[idx] == tag);
  wire [LINE_W-1:0] cur_line = m_data[idx];

  logic [VB_N-1:0] vb_match, oldest;
  logic [VB_W-1:0] hit_e, victim;
  logic            dup;

  always_comb begin
    hit_e = '0;
    victim = '0;
    dup = 1'b0;
    for (int i = 0; i < VB_N; i++) begin
      vb_match[i] = vb_val[i] && (vb_la[i] == la);
      oldest[i]   = (vb_age[i] == VB_W'(VB_N - 1));
      if (vb_match[i]) hit_e = VB_W'(i);
      if (oldest[i])   victim = VB_W'(i);
      if (vb_val[i] && m_val[vb_la[i][IDX_W-1:0]] &&
          m_tag[vb_la[i][IDX_W-1:0]] == vb_la[i][LA_W-1 -: TAG_W]) dup = 1'b1;
    end
    for (int i = VB_N - 1; i >= 0; i--)
      if (!vb_val[i]) victim = VB_W'(i);
  end

  assign cpu_ready      = (state == S_IDLE);
  assign cpu_resp_valid = (state == S_LOOK) && m_hit;
  assign cpu_rdata      = cur_line[off*DATA_W +: DATA_W];
  assign mem_req_valid  = (state == S_WB) || (state == S_FETCH);
  assign mem_req_we     = (state == S_WB);
  assign mem_req_addr   = (state == S_WB) ? vb_la[slot] : la;
  assign mem_req_wdata  = vb_data[slot];

  wire             touch   = (state == S_MOVE) || (state == S_PROBE && |vb_match);
  wire [VB_W-1:0]  touch_e = (state == S_MOVE) ? slot : hit_e;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < VB_N; i++) vb_age[i] <= VB_W'(i);
    end else if (touch) begin
      for (int i = 0; i < VB_N; i++)
        if (VB_W'(i) == touch_e) vb_age[i] <= '0;
        else if (vb_age[i] < vb_age[touch_e]) vb_age[i] <= vb_age[i] + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      m_val    <= '0;
      m_dirty  <= '0;
      vb_val   <= '0;
      vb_dirty <= '0;
      slot     <= '0;
      req_we   <= 1'b0;
      req_addr <= '0;
      req_wdata <= '0;
    end else begin
      case (state)
        S_IDLE: if (cpu_req) begin
          req_we    <= cpu_we;
          req_addr  <= cpu_addr;
          req_wdata <= cpu_wdata;
          state     <= S_LOOK;
        end
        S_LOOK: if (m_hit) begin
          if (req_we) begin
            m_data[idx][off*DATA_W +: DATA_W] <= req_wdata;
            m_dirty[idx] <= 1'b1;
          end
          state <= S_IDLE;
        end else state <= S_PROBE;
        S_PROBE: if (|vb_match) begin
          m_data[idx]     <= vb_data[hit_e];
          m_tag[idx]      <= tag;
          m_val[idx]      <= 1'b1;
          m_dirty[idx]    <= vb_dirty[hit_e];
          vb_data[hit_e]  <= m_data[idx];
          vb_la[hit_e]    <= {m_tag[idx], idx};
          vb_val[hit_e]   <= m_val[idx];
          vb_dirty[hit_e] <= m_dirty[idx];
          state <= S_LOOK;
        end else if (m_val[idx]) begin
          slot  <= victim;
          state <= (vb_val[victim] && vb_dirty[victim]) ? S_WB : S_MOVE;
        end else state <= S_FETCH;
        S_WB: if (mem_req_ready) state <= S_MOVE;
        S_MOVE: begin
          vb_data[slot]  <= m_data[idx];
          vb_la[slot]    <= {m_tag[idx], idx};
          vb_val[slot]   <= 1'b1;
          vb_dirty[slot] <= m_dirty[idx];
          m_val[idx]     <= 1'b0;
          state <= S_FETCH;
        end
        S_FETCH: if (mem_req_ready) state <= S_WAIT;
        S_WAIT: if (mem_resp_valid) begin
          m_data[idx]  <= mem_resp_data;
          m_tag[idx]   <= tag;
          m_val[idx]   <= 1'b1;
          m_dirty[idx] <= 1'b0;
          state <= S_LOOK;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_vb_unique_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(vb_match));
  assert_no_dup_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE) |-> !dup);
  assert_lru_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(oldest) == 1);
  assert_wb_dirty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_we) |-> (vb_val[slot] && vb_dirty[slot]));
  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we)));
endmodule

// File: tb/tb_victim_assist_cache.sv
module tb_victim_assist_cache;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_req = 1'b0, cpu_we = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic cpu_ready, cpu_resp_valid;
  logic [31:0] cpu_rdata;
  logic mem_req_valid, mem_req_we;
  logic [13:0] mem_req_addr;
  logic [127:0] mem_req_wdata;
  logic mem_req_ready = 1'b0, mem_resp_valid = 1'b0;
  logic [127:0] mem_resp_data = '0;

  always #2 clk = ~clk;

  victim_assist_cache dut (.*);

  int checks = 0, errors = 0;
  int rd_cnt = 0, wr_cnt = 0, hold_err = 0;
  logic [13:0]  last_wa = '0;
  logic [127:0] last_wd = '0;
  logic [127:0] wmem [int];

  function automatic logic [127:0] mem_line(logic [13:0] la);
    if (wmem.exists(int'(la))) return wmem[int'(la)];
    for (int w = 0; w < 4; w++) mem_line[w*32 +: 32] = {2'b10, la, 14'h0, 2'(w)};
  endfunction

  logic cap_we, resp_pend = 1'b0, prev_v = 1'b0, prev_r = 1'b0;
  logic [13:0] cap_a, pend_a;
  logic [127:0] cap_d;

  always @(negedge clk) begin
    if (prev_v && !prev_r && !(mem_req_valid && mem_req_addr == cap_a && mem_req_we == cap_we))
      hold_err++;
    if (mem_resp_valid) mem_resp_valid = 1'b0;
    if (resp_pend) begin
      mem_resp_valid = 1'b1; mem_resp_data = mem_line(pend_a); resp_pend = 1'b0;
    end
    if (mem_req_ready) begin
      mem_req_ready = 1'b0;
      if (cap_we) begin wmem[int'(cap_a)] = cap_d; wr_cnt++; last_wa = cap_a; last_wd = cap_d; end
      else begin rd_cnt++; pend_a = cap_a; resp_pend = 1'b1; end
    end else if (mem_req_valid) begin
      if (prev_v) mem_req_ready = 1'b1;
      cap_a = mem_req_addr; cap_we = mem_req_we; cap_d = mem_req_wdata;
    end
    prev_v = mem_req_valid && rst_n;
    prev_r = mem_req_ready;
  end

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp); end
  endtask

  task automatic access(input logic we, input logic [15:0] a, input logic [31:0] d,
                        output logic [31:0] rd, output int lat);
    @(negedge clk); cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    @(negedge clk); cpu_req = 1'b0; lat = 0;
    while (!cpu_resp_valid && lat < 1000) begin @(negedge clk); lat++; end
    rd = cpu_rdata;
  endtask

  // {req4, we, addr16, wdata32, exp32, reads4, writes4, wb_addr14}
  localparam int NV = 20;
  localparam logic [106:0] VEC [NV] = '{
    {4'd4, 1'b0, 16'h0011, 32'h0, 32'h80040001, 4'd1, 4'd0, 14'h0},   // R4 cold miss
    {4'd2, 1'b0, 16'h0011, 32'h0, 32'h80040001, 4'd0, 4'd0, 14'h0},   // R2 hit
    {4'd3, 1'b1, 16'h0012, 32'hDEADBEEF, 32'h0, 4'd0, 4'd0, 14'h0},   // R3 write hit
    {4'd3, 1'b0, 16'h0012, 32'h0, 32'hDEADBEEF, 4'd0, 4'd0, 14'h0},   // R3
    {4'd5, 1'b0, 16'h0410, 32'h0, 32'h81040000, 4'd1, 4'd0, 14'h0},   // R5 displace
    {4'd5, 1'b0, 16'h0012, 32'h0, 32'hDEADBEEF, 4'd0, 4'd0, 14'h0},   // R5 swap
    {4'd6, 1'b0, 16'h0413, 32'h0, 32'h81040003, 4'd0, 4'd0, 14'h0},   // R6
    {4'd6, 1'b0, 16'h0011, 32'h0, 32'h80040001, 4'd0, 4'd0, 14'h0},   // R6
    {4'd7, 1'b0, 16'h0810, 32'h0, 32'h82040000, 4'd1, 4'd0, 14'h0},   // R7 fill
    {4'd7, 1'b0, 16'h0C10, 32'h0, 32'h83040000, 4'd1, 4'd0, 14'h0},   // R7
    {4'd7, 1'b0, 16'h1010, 32'h0, 32'h84040000, 4'd1, 4'd0, 14'h0},   // R7 buffer full
    {4'd7, 1'b0, 16'h1410, 32'h0, 32'h85040000, 4'd1, 4'd0, 14'h0},   // R7 clean LRU out
    {4'd8, 1'b0, 16'h0410, 32'h0, 32'h81040000, 4'd1, 4'd1, 14'h004}, // R8 dirty LRU out
    {4'd8, 1'b0, 16'h0012, 32'h0, 32'hDEADBEEF, 4'd1, 4'd0, 14'h0},   // R8 data survived
    {4'd7, 1'b0, 16'h0810, 32'h0, 32'h82040000, 4'd1, 4'd0, 14'h0},   // R7
    {4'd9, 1'b1, 16'h0C11, 32'h12345678, 32'h0, 4'd1, 4'd0, 14'h0},   // R9 write miss
    {4'd9, 1'b0, 16'h0C11, 32'h0, 32'h12345678, 4'd0, 4'd0, 14'h0},   // R9
    {4'd3, 1'b0, 16'h0C10, 32'h0, 32'h83040000, 4'd0, 4'd0, 14'h0},   // R3 neighbour word
    {4'd6, 1'b1, 16'h1413, 32'hCAFEF00D, 32'h0, 4'd0, 4'd0, 14'h0},   // R6 write after swap
    {4'd6, 1'b0, 16'h0C11, 32'h0, 32'h12345678, 4'd0, 4'd0, 14'h0}    // R6 dirty kept
  };

  initial begin
    logic [31:0] rd;
    int lat, r0, w0;
    repeat (3) @(negedge clk);
    chk(cpu_ready && !cpu_resp_valid && !mem_req_valid, "R1 in reset", {cpu_ready, cpu_resp_valid, mem_req_valid}, 3'b100);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cpu_ready && !cpu_resp_valid && !mem_req_valid, "R1 after reset", {cpu_ready, cpu_resp_valid, mem_req_valid}, 3'b100);

    for (int i = 0; i < NV; i++) begin
      logic [106:0] v;
      string tg;
      v = VEC[i];
      tg = $sformatf("R%0d row %0d", v[106:103], i);
      r0 = rd_cnt; w0 = wr_cnt;
      access(v[102], v[101:86], v[85:54], rd, lat);
      if (!v[102]) chk(rd == v[53:22], {tg, " data"}, rd, v[53:22]);
      chk(rd_cnt - r0 == int'(v[21:18]), {tg, " reads"}, rd_cnt - r0, v[21:18]);
      chk(wr_cnt - w0 == int'(v[17:14]), {tg, " writes"}, wr_cnt - w0, v[17:14]);
      if (v[17:14] != 0) chk(last_wa == v[13:0], {tg, " wb addr"}, last_wa, v[13:0]);
    end

    // R8 full dirty line written back
    chk(last_wd == {32'h80040003, 32'hDEADBEEF, 32'h80040001, 32'h80040000}, "R8 wb line", last_wd,
        {32'h80040003, 32'hDEADBEEF, 32'h80040001, 32'h80040000});
    // R5 buffer hit latency
    r0 = rd_cnt;
    access(1'b0, 16'h1413, 32'h0, rd, lat);
    chk(rd == 32'hCAFEF00D, "R5 buffer hit data", rd, 32'hCAFEF00D);
    chk(lat == 2, "R5 buffer hit latency", lat, 2);
    // R2 main hit latency, no traffic
    access(1'b0, 16'h1413, 32'h0, rd, lat);
    chk(lat == 0, "R2 hit latency", lat, 0);
    chk(rd_cnt == r0, "R2 no memory read", rd_cnt, r0);
    // R10 request hold
    chk(hold_err == 0, "R10 request held", hold_err, 0);
    // R1 reset mid-run discards contents
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk(cpu_ready && !mem_req_valid, "R1 mid reset", {cpu_ready, mem_req_valid}, 2'b10);
    rst_n = 1'b1;
    r0 = rd_cnt; w0 = wr_cnt;
    access(1'b0, 16'h1413, 32'h0, rd, lat);
    chk(rd == 32'h85040003, "R1 contents dropped", rd, 32'h85040003);
    chk(rd_cnt - r0 == 1 && wr_cnt == w0, "R1 refetch only", {rd_cnt - r0, wr_cnt - w0}, {32'd1, 32'd0});

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule